// File: doc/BRIEF.md
# Backdoor Key Security Unlock Controller

This block executes a single memory-controller command that tries to release device security with a 64-bit backdoor key. Software first fills a command parameter buffer with an opcode word and four 16-bit key words. It then launches the command by clearing the command-complete flag. The block checks the launch conditions and compares the supplied key against a stored comparison key, one word per clock. When every word matches, it opens the security-released output.

The stored comparison key and the 2-bit key-enable field come in as inputs from a configuration-field model. A wrong key raises the access-error flag. It also sets a lockout bit that lasts until reset, and while that bit is set every later attempt is aborted. The access-error flag is sticky. It clears only through a write-one-to-clear strobe, and no command can launch while it is set.

Top module: `bdk_unlock`

## Requirements
- R1: After reset, `cmd_done_o` is 1, and `acc_err_o`, `sec_open_o` and `locked_o` are 0.
- R2: A launch is accepted only when `launch_i` is high, `cmd_done_o` is 1, `acc_err_o` is 0 and `opcode_i` equals 8'h0D. On the next clock `cmd_done_o` drops to 0. A launch with any other opcode is ignored: `cmd_done_o` stays 1 and no flag changes.
- R3: A command launched with `key_en_i` not equal to 2'b10 sets `acc_err_o`, skips the compare, and leaves `sec_open_o` and `locked_o` unchanged.
- R4: A command launched with `param_idx_i` not equal to 3'b100 sets `acc_err_o` and skips the compare.
- R5: A command launched while `load_active_i` is 1 sets `acc_err_o` and skips the compare.
- R6: Key word i is bits [16i+15:16i] of `key_i`, and it is compared with bits [16i+15:16i] of `stored_key_i`, starting with word 0. When all four words match, `sec_open_o` becomes 1 and `acc_err_o` stays 0. `sec_open_o` then stays 1 until reset.
- R7: A mismatch on any word sets both `acc_err_o` and `locked_o` and does not set `sec_open_o`.
- R8: While `locked_o` is 1, every launched command is aborted with `acc_err_o` set, even when the key is correct. Only reset clears `locked_o`.
- R9: `acc_err_o` stays set until `err_clr_i` is pulsed. While it is set, a launch is ignored and `cmd_done_o` stays 1.
- R10: Counting clocks after the clock edge that accepts the launch, `cmd_done_o` returns to 1 as follows:
  - after 1 clock for a failed launch condition or lockout;
  - after 2+k clocks for a first mismatch at word k;
  - after 5 clocks for a full match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch_i | input | 1 | Write-one-to-clear strobe on the command-complete flag (launch) |
| err_clr_i | input | 1 | Write-one-to-clear strobe on the access-error flag |
| opcode_i | input | 8 | Command opcode word from the parameter buffer |
| param_idx_i | input | 3 | Parameter index register value at launch |
| key_i | input | 64 | Four supplied key words, word 0 in the low bits |
| load_active_i | input | 1 | A load-data-field command sequence is in progress |
| key_en_i | input | 2 | Backdoor enable field from the configuration model |
| stored_key_i | input | 64 | Stored comparison key, lowest word in the low bits |
| cmd_done_o | output | 1 | Command-complete flag |
| acc_err_o | output | 1 | Sticky access-error flag |
| sec_open_o | output | 1 | Security released |
| locked_o | output | 1 | Backdoor lockout until reset |

## Verification
The bench builds the block with its default parameters: four 16-bit key words and a 3-bit parameter index. With these values every compare position is reachable. Mismatches are placed in word 0, word 2 and word 3, and the bench checks that each one finishes on its own predicted clock. A reversed key proves the word order. Separate resets put each lockout, release and sticky-flag case into a fresh state.

// File: rtl/bdk_pkg.sv
`timescale 1ns/1ps
package bdk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_CMP   = 2'd2
    } bdk_state_e;

endpackage

// File: rtl/bdk_gate.sv
`timescale 1ns/1ps
module bdk_gate #(
    parameter int          IDX_W     = 3,
    parameter int          EN_W      = 2,
    parameter int          KEY_WORDS = 4,
    parameter logic [EN_W-1:0] EN_OK = 2'b10
) (
    input  logic [IDX_W-1:0] pidx_i,
    input  logic [EN_W-1:0]  ken_i,
    input  logic             lact_i,
    input  logic             locked_i,
    output logic             fault_o
);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(KEY_WORDS);

    logic [3:0] cause;

    always_comb begin
        cause[0] = (ken_i != EN_OK);
        cause[1] = (pidx_i != IDX_FULL);
        cause[2] = lact_i;
        cause[3] = locked_i;
        fault_o  = |cause;
    end
endmodule

// File: rtl/bdk_cmp.sv
`timescale 1ns/1ps
module bdk_cmp #(
    parameter int WORD_W    = 16,
    parameter int KEY_WORDS = 4,
    parameter int CNT_W     = 2
) (
    input  logic [WORD_W*KEY_WORDS-1:0] key_i,
    input  logic [WORD_W*KEY_WORDS-1:0] ref_i,
    input  logic [CNT_W-1:0]            sel_i,
    output logic                        word_ok_o
);
    logic [KEY_WORDS-1:0] hit;

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        assign hit[g] = (key_i[g*WORD_W +: WORD_W] == ref_i[g*WORD_W +: WORD_W]);
    end

    always_comb begin
        word_ok_o = 1'b0;
        for (int i = 0; i < KEY_WORDS; i++) begin
            if (sel_i == CNT_W'(i)) word_ok_o = hit[i];
        end
    end
endmodule

// File: rtl/bdk_unlock.sv
`timescale 1ns/1ps
module bdk_unlock
    import bdk_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              KEY_WORDS = 4,
    parameter int              IDX_W     = 3,
    parameter int              OP_W      = 8,
    parameter int              EN_W      = 2,
    parameter logic [OP_W-1:0] OPCODE    = 8'h0D,
    parameter logic [EN_W-1:0] EN_OK     = 2'b10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        launch_i,
    input  logic                        err_clr_i,
    input  logic [OP_W-1:0]             opcode_i,
    input  logic [IDX_W-1:0]            param_idx_i,
    input  logic [WORD_W*KEY_WORDS-1:0] key_i,
    input  logic                        load_active_i,
    input  logic [EN_W-1:0]             key_en_i,
    input  logic [WORD_W*KEY_WORDS-1:0] stored_key_i,
    output logic                        cmd_done_o,
    output logic                        acc_err_o,
    output logic                        sec_open_o,
    output logic                        locked_o
);
    localparam int KEY_W = WORD_W * KEY_WORDS;
    localparam int CNT_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_WORDS - 1);

    typedef struct packed {
        bdk_state_e       state;
        logic             done;
        logic             err;
        logic             open;
        logic             lock;
        logic [CNT_W-1:0] widx;
        logic [KEY_W-1:0] key;
        logic [IDX_W-1:0] pidx;
        logic [EN_W-1:0]  ken;
        logic             lact;
    } bdk_regs_t;

    bdk_regs_t st_d, st_q;
    logic      gate_fault;
    logic      word_ok;
    logic      accept;

    bdk_gate #(
        .IDX_W     (IDX_W),
        .EN_W      (EN_W),
        .KEY_WORDS (KEY_WORDS),
        .EN_OK     (EN_OK)
    ) u_gate (
        .pidx_i   (st_q.pidx),
        .ken_i    (st_q.ken),
        .lact_i   (st_q.lact),
        .locked_i (st_q.lock),
        .fault_o  (gate_fault)
    );

    bdk_cmp #(
        .WORD_W    (WORD_W),
        .KEY_WORDS (KEY_WORDS),
        .CNT_W     (CNT_W)
    ) u_cmp (
        .key_i     (st_q.key),
        .ref_i     (stored_key_i),
        .sel_i     (st_q.widx),
        .word_ok_o (word_ok)
    );

    assign accept = launch_i && st_q.done && !st_q.err && (opcode_i == OPCODE);

    always_comb begin
        st_d = st_q;
        if (err_clr_i) st_d.err = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (accept) begin
                    st_d.done  = 1'b0;
                    st_d.state = ST_CHECK;
                    st_d.key   = key_i;
                    st_d.pidx  = param_idx_i;
                    st_d.ken   = key_en_i;
                    st_d.lact  = load_active_i;
                    st_d.widx  = '0;
                end
            end
            ST_CHECK: begin
                if (gate_fault) begin
                    st_d.err   = 1'b1;
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.state = ST_CMP;
                end
            end
            ST_CMP: begin
                if (!word_ok) begin
                    st_d.err   = 1'b1;
                    st_d.lock  = 1'b1;
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end else if (st_q.widx == LAST) begin
                    st_d.open  = 1'b1;
                    st_d.done  = 1'b1;
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.widx = st_q.widx + 1'b1;
                end
            end
            default: begin
                st_d.state = ST_IDLE;
                st_d.done  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.done  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_done_o = st_q.done;
    assign acc_err_o  = st_q.err;
    assign sec_open_o = st_q.open;
    assign locked_o   = st_q.lock;
endmodule

// File: rtl/bdk_unlock_chk.sv
`timescale 1ns/1ps
module bdk_unlock_chk #(
    parameter int KEY_WORDS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic launch_i,
    input logic err_clr_i,
    input logic cmd_done_o,
    input logic acc_err_o,
    input logic sec_open_o,
    input logic locked_o
);
    localparam int MAX_BUSY = KEY_WORDS + 1;

    int busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           busy_cnt <= 0;
        else if (cmd_done_o)  busy_cnt <= 0;
        else                  busy_cnt <= busy_cnt + 1;
    end

    // R10
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= MAX_BUSY);

    // R2
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_o && !launch_i) |=> cmd_done_o);

    // R9
    err_blocks_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_o && acc_err_o) |=> cmd_done_o);

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_o && err_clr_i) |=> !acc_err_o);

    // R8
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);

    // R7
    lock_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> (acc_err_o && $rose(cmd_done_o)));

    // R6
    open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_open_o |=> sec_open_o);

    // R6
    open_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_open_o) |-> ($rose(cmd_done_o) && !locked_o));
endmodule

bind bdk_unlock bdk_unlock_chk #(.KEY_WORDS(KEY_WORDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch_i   (launch_i),
    .err_clr_i  (err_clr_i),
    .cmd_done_o (cmd_done_o),
    .acc_err_o  (acc_err_o),
    .sec_open_o (sec_open_o),
    .locked_o   (locked_o)
);

// File: tb/bdk_unlock_tb.sv
`timescale 1ns/1ps
module bdk_unlock_tb;
    localparam logic [63:0] STORED = 64'h1111_2222_3333_4444;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_i = 1'b0;
    logic        err_clr_i = 1'b0;
    logic [7:0]  opcode_i = 8'h0D;
    logic [2:0]  param_idx_i = 3'b100;
    logic [63:0] key_i = '0;
    logic        load_active_i = 1'b0;
    logic [1:0]  key_en_i = 2'b10;
    logic [63:0] stored_key_i = STORED;
    logic        cmd_done_o, acc_err_o, sec_open_o, locked_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bdk_unlock u_dut (
        .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .err_clr_i(err_clr_i),
        .opcode_i(opcode_i), .param_idx_i(param_idx_i), .key_i(key_i),
        .load_active_i(load_active_i), .key_en_i(key_en_i),
        .stored_key_i(stored_key_i), .cmd_done_o(cmd_done_o),
        .acc_err_o(acc_err_o), .sec_open_o(sec_open_o), .locked_o(locked_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
    endtask

    // returns 0 if the launch was not accepted, else clocks until done
    task automatic run_cmd(input logic [7:0] op, input logic [2:0] idx,
                           input logic [1:0] en, input logic la,
                           input logic [63:0] key, output int cycles);
        @(negedge clk);
        opcode_i = op; param_idx_i = idx; key_en_i = en;
        load_active_i = la; key_i = key; launch_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        launch_i = 1'b0;
        cycles = 0;
        if (!cmd_done_o) begin
            while (!cmd_done_o && cycles < 20) begin
                @(posedge clk);
                @(negedge clk);
                cycles++;
            end
        end
        opcode_i = 8'h0D; param_idx_i = 3'b100; key_en_i = 2'b10; load_active_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 done", cmd_done_o, 1);
        chk("R1 err", acc_err_o, 0);
        chk("R1 open", sec_open_o, 0);
        chk("R1 locked", locked_o, 0);
    endtask

    task automatic t_precond();
        int c;
        run_cmd(8'h0D, 3'b100, 2'b11, 1'b0, STORED, c);
        chk("R3 cycles en=11", c, 1);
        chk("R3 err", acc_err_o, 1);
        chk("R3 open", sec_open_o, 0);
        chk("R3 lock", locked_o, 0);
        clear_err();
        chk("R9 cleared", acc_err_o, 0);
        run_cmd(8'h0D, 3'b100, 2'b01, 1'b0, STORED, c);
        chk("R3 cycles en=01", c, 1);
        chk("R3 err en=01", acc_err_o, 1);
        clear_err();
        run_cmd(8'h0D, 3'b011, 2'b10, 1'b0, STORED, c);
        chk("R4 cycles", c, 1);
        chk("R4 err", acc_err_o, 1);
        chk("R4 open", sec_open_o, 0);
        clear_err();
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b1, STORED, c);
        chk("R5 cycles", c, 1);
        chk("R5 err", acc_err_o, 1);
        chk("R5 lock", locked_o, 0);
        clear_err();
    endtask

    task automatic t_opcode();
        int c;
        run_cmd(8'h0C, 3'b100, 2'b10, 1'b0, STORED, c);
        chk("R2 wrong opcode ignored", c, 0);
        repeat (6) @(negedge clk);
        chk("R2 done held", cmd_done_o, 1);
        chk("R2 open unchanged", sec_open_o, 0);
        chk("R2 err unchanged", acc_err_o, 0);
    endtask

    task automatic t_err_block();
        int c;
        run_cmd(8'h0D, 3'b100, 2'b00, 1'b0, STORED, c);
        chk("R9 setup err", acc_err_o, 1);
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b0, STORED, c);
        chk("R9 launch ignored", c, 0);
        repeat (6) @(negedge clk);
        chk("R9 open unchanged", sec_open_o, 0);
        chk("R9 err held", acc_err_o, 1);
        clear_err();
        chk("R9 err cleared", acc_err_o, 0);
    endtask

    task automatic t_order();
        int c;
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b0, 64'h4444_3333_2222_1111, c);
        chk("R10 word0 mismatch cycles", c, 2);
        chk("R6 reversed order rejected", sec_open_o, 0);
        chk("R7 err", acc_err_o, 1);
        chk("R7 lock", locked_o, 1);
    endtask

    task automatic t_lockout();
        int c;
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b0, 64'h1111_2299_3333_4444, c);
        chk("R10 word2 mismatch cycles", c, 4);
        chk("R7 lock word2", locked_o, 1);
        chk("R7 open", sec_open_o, 0);
        clear_err();
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b0, STORED, c);
        chk("R8 aborted cycles", c, 1);
        chk("R8 err", acc_err_o, 1);
        chk("R8 open", sec_open_o, 0);
        chk("R8 still locked", locked_o, 1);
        do_reset();
        chk("R8 reset clears lock", locked_o, 0);
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b0, 64'h1199_2222_3333_4444, c);
        chk("R10 word3 mismatch cycles", c, 5);
        chk("R7 lock word3", locked_o, 1);
    endtask

    task automatic t_match();
        int c;
        run_cmd(8'h0D, 3'b100, 2'b10, 1'b0, STORED, c);
        chk("R10 match cycles", c, 5);
        chk("R6 open", sec_open_o, 1);
        chk("R6 err", acc_err_o, 0);
        chk("R6 no lock", locked_o, 0);
        run_cmd(8'h0D, 3'b100, 2'b11, 1'b0, STORED, c);
        chk("R6 open held after failed cmd", sec_open_o, 1);
        chk("R3 err after open", acc_err_o, 1);
    endtask

    initial begin
        t_reset();
        t_precond();
        t_opcode();
        t_err_block();
        t_order();
        do_reset();
        t_lockout();
        do_reset();
        t_match();
        repeat (3) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end
endmodule